// File: doc/BRIEF.md
# Crosspoint Serial Configuration Loader

This block is the serial front end of a 16-input, 8-output routing matrix. It listens on a slow three-wire serial port: a serial clock, a data line and an active-low select. It fills a staged bank that holds one entry per matrix output. Each entry has a 4-bit source index and a disable flag. The serial pins are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The serial clock must therefore run at no more than one quarter of the system clock rate.

A mode input chooses between two formats. In serial mode the whole bank is a 40-bit shift chain. Each received bit enters at the far end, and the oldest bit leaves on a data-out pin. Several loaders can then be daisy-chained: an 80-clock burst fills two of them. In addressed mode a short 8-bit word rewrites the entry of a single output, and the other entries are left alone. A one-cycle pulse marks every change to the staged bank, so the next stage, which applies the bank to the live matrix, can tell fresh data from an unchanged bank.

Top module: `xpt_cfg_loader`

## Requirements
- R1: After reset every staged entry reads disabled with source 0. Each 5-bit entry k sits at stage_o[5k+4:5k], with bits 3..0 holding the source index and bit 4 the disable flag (1 = disabled). sdout_o and stage_upd_o are 0.
- R2: While csn_i is high, serial clock and data activity leaves the bank unchanged and produces no stage_upd_o pulse.
- R3: After csn_i falls, a falling serial clock edge that comes before the first rising edge is not sampled. The first rising edge arms the receiver, and every bit after that is taken on a falling edge.
- R4: With mode_i low, the 40 bits sent are placed so that the first bit received lands at stage_o[0] and the last at stage_o[39]. Entry k therefore takes frame bits 5k..5k+4, source index LSB first, then the disable flag.
- R5: With mode_i low, each sampled bit shifts the chain by one place. sdout_o always presents the bit that leaves next (stage_o[0]), so bits sent past 40 push the earlier frame out of sdout_o in arrival order.
- R6: With mode_i high, an 8-bit word is received LSB first. Bits 2..0 give the output index, bits 6..3 the source index and bit 7 the disable flag. Only the named entry is rewritten, with {bit7, bits6..3}.
- R7: In addressed mode the entry is written on the eighth bit. Bits after the eighth, up to the rise of csn_i, are dropped. A word cut short by csn_i rising changes nothing, and the next select period starts a fresh word.
- R8: stage_upd_o pulses for exactly one system cycle for every change to the bank: once per sampled bit in serial mode and once per completed word in addressed mode. It is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low select |
| mode_i | input | 1 | 0 = whole-bank shift chain, 1 = addressed word |
| sdout_o | output | 1 | Bit leaving the shift chain |
| stage_o | output | 40 | Staged bank, 8 entries of 5 bits |
| stage_upd_o | output | 1 | One-cycle pulse on a bank change |

## Verification
A serial clock edge at the pin reaches the bank on the third system clock edge after it. Two of those edges are spent in the synchronizer and one in the edge register. stage_o, sdout_o and stage_upd_o all change on that same edge. The bench holds each serial clock level for four system cycles and reads the bank only after the last phase of a transfer has settled. It counts update pulses on the falling system clock edge, so a one-cycle pulse is seen exactly once. The daisy-chain check reads sdout_o just before each new bit is driven, which is after the previous shift has taken effect.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  typedef enum logic {
    LOAD_CHAIN = 1'b0,
    LOAD_ADDR  = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xpt_edge_arm.sv
module xpt_edge_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic cs_act_i,
  output logic armed_o,
  output logic sample_o
);
  logic prev_q, armed_q;
  logic rise, fall;

  assign rise = sclk_s_i & ~prev_q;
  assign fall = ~sclk_s_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= sclk_s_i;
      if (!cs_act_i)  armed_q <= 1'b0;
      else if (rise)  armed_q <= 1'b1;
    end
  end

  assign armed_o  = armed_q;
  // falls before the arming rise are ignored
  assign sample_o = fall & armed_q & cs_act_i;
endmodule

// File: rtl/xpt_load_bank.sv
module xpt_load_bank
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 8,
  localparam int unsigned IN_AW   = $clog2(N_IN),
  localparam int unsigned OUT_AW  = $clog2(N_OUT),
  localparam int unsigned FIELD_W = IN_AW + 1,
  localparam int unsigned FRAME_W = FIELD_W * N_OUT,
  localparam int unsigned WORD_W  = OUT_AW + IN_AW + 1,
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               din_i,
  input  load_mode_e         mode_i,
  input  logic               cs_act_i,
  output logic [FRAME_W-1:0] stage_o,
  output logic               sdout_o,
  output logic               upd_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);
  localparam logic [FIELD_W-1:0] FIELD_RST = {1'b1, {IN_AW{1'b0}}};

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [WORD_W-1:0]  word_q, word_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic               upd_q;
  logic               chain_shift, addr_take, addr_last;
  logic [OUT_AW-1:0]  tgt_out;
  logic [FIELD_W-1:0] tgt_field;

  assign chain_shift = sample_i && (mode_i == LOAD_CHAIN);
  assign addr_take   = sample_i && (mode_i == LOAD_ADDR) && (cnt_q < CNT_W'(WORD_W));
  assign addr_last   = addr_take && (cnt_q == CNT_W'(WORD_W - 1));
  assign word_nx     = {din_i, word_q[WORD_W-1:1]};
  assign tgt_out     = word_nx[OUT_AW-1:0];
  assign tgt_field   = {word_nx[WORD_W-1], word_nx[OUT_AW +: IN_AW]};

  always_comb begin
    frame_d = frame_q;
    if (chain_shift) begin
      frame_d = {din_i, frame_q[FRAME_W-1:1]};
    end else if (addr_last) begin
      for (int k = 0; k < int'(N_OUT); k++) begin
        if (tgt_out == OUT_AW'(k)) frame_d[k*FIELD_W +: FIELD_W] = tgt_field;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= {N_OUT{FIELD_RST}};
      word_q  <= '0;
      cnt_q   <= '0;
      upd_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      upd_q   <= chain_shift || addr_last;
      if (!cs_act_i) begin
        cnt_q  <= '0;
        word_q <= '0;
      end else if (addr_take) begin
        cnt_q  <= cnt_q + 1'b1;
        word_q <= word_nx;
      end
    end
  end

  assign stage_o   = frame_q;
  assign sdout_o   = frame_q[0];
  assign upd_o     = upd_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/xpt_cfg_loader.sv
module xpt_cfg_loader
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned N_IN        = 16,
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IN_AW   = $clog2(N_IN),
  localparam int unsigned OUT_AW  = $clog2(N_OUT),
  localparam int unsigned FIELD_W = IN_AW + 1,
  localparam int unsigned FRAME_W = FIELD_W * N_OUT,
  localparam int unsigned WORD_W  = OUT_AW + IN_AW + 1,
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               csn_i,
  input  logic               mode_i,
  output logic               sdout_o,
  output logic [FRAME_W-1:0] stage_o,
  output logic               stage_upd_o
);
  logic [3:0]       pins_s;
  logic             sclk_s, sdata_s, csn_s, mode_s;
  logic             cs_act, armed, sample;
  load_mode_e       mode_e;
  logic [CNT_W-1:0] bit_cnt;

  xpt_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mode_i, csn_i, sdata_i, sclk_i}),
    .q_o    (pins_s)
  );

  assign {mode_s, csn_s, sdata_s, sclk_s} = pins_s;
  assign cs_act = ~csn_s;
  assign mode_e = load_mode_e'(mode_s);

  xpt_edge_arm u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .cs_act_i (cs_act),
    .armed_o  (armed),
    .sample_o (sample)
  );

  xpt_load_bank #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample),
    .din_i     (sdata_s),
    .mode_i    (mode_e),
    .cs_act_i  (cs_act),
    .stage_o   (stage_o),
    .sdout_o   (sdout_o),
    .upd_o     (stage_upd_o),
    .bit_cnt_o (bit_cnt)
  );
endmodule

// File: rtl/xpt_cfg_loader_chk.sv
module xpt_cfg_loader_chk #(
  parameter int unsigned FRAME_W = 40,
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [FRAME_W-1:0] stage_o,
  input logic               sdout_o,
  input logic               stage_upd_o,
  input logic               cs_act,
  input logic               armed,
  input logic               mode_s,
  input logic [CNT_W-1:0]   bit_cnt
);
  // R2
  idle_select_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> $stable(stage_o));

  // R3
  change_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stage_o) |-> $past(armed));

  // R5
  chain_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_upd_o && !mode_s) |-> (sdout_o == $past(stage_o[1])));

  // R7
  word_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_upd_o && mode_s) |-> (bit_cnt == CNT_W'(WORD_W)));

  // R8
  change_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stage_o) |-> stage_upd_o);

  // R8
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_upd_o |=> !stage_upd_o);
endmodule

bind xpt_cfg_loader xpt_cfg_loader_chk #(
  .FRAME_W (FRAME_W),
  .WORD_W  (WORD_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stage_o     (stage_o),
  .sdout_o     (sdout_o),
  .stage_upd_o (stage_upd_o),
  .cs_act      (cs_act),
  .armed       (armed),
  .mode_s      (mode_s),
  .bit_cnt     (bit_cnt)
);

// File: tb/xpt_cfg_loader_bench.sv
`timescale 1ns/1ps
module xpt_cfg_loader_bench;
  localparam int HALF = 4;
  localparam logic [4:0] OFF0 = 5'h10;
  // {word, output index, expected entry}
  localparam logic [15:0] VEC [6] = '{
    {8'h4B, 3'd3, 5'h09},
    {8'hF8, 3'd0, 5'h1F},
    {8'h07, 3'd7, 5'h00},
    {8'h35, 3'd5, 5'h06},
    {8'h93, 3'd3, 5'h12},
    {8'h61, 3'd1, 5'h0C}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, csn = 1'b1, mode = 1'b0;
  logic sdout, upd;
  logic [39:0] stage;
  int checks = 0, failures = 0, upd_cnt = 0;
  logic [39:0] exp_bank, fa, fb;

  always #2 clk = ~clk;

  xpt_cfg_loader u_xpt_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .csn_i(csn), .mode_i(mode), .sdout_o(sdout), .stage_o(stage),
    .stage_upd_o(upd)
  );

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    wait_n(HALF);
    sclk = 1'b0;
    wait_n(HALF);
  endtask

  task automatic sel_on;
    @(negedge clk); csn = 1'b0; wait_n(HALF);
  endtask

  task automatic sel_off;
    wait_n(HALF); csn = 1'b1; wait_n(HALF);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) send_bit(w[i]);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base, errs;
    for (int k = 0; k < 8; k++) begin
      fa[5*k +: 5] = {k == 5, 4'(15 - k)};
      fb[5*k +: 5] = {k[0], 4'(k * 3 + 1)};
    end
    wait_n(4); rst_n = 1'b1; wait_n(4);

    // R1 reset state
    exp_bank = {8{OFF0}};
    check(stage == exp_bank, "R1 stage", stage, exp_bank);
    check(sdout == 1'b0 && upd_cnt == 0, "R1 sdout/upd", {sdout, 8'(upd_cnt)}, 0);

    // R6 table walk in addressed mode
    mode = 1'b1;
    foreach (VEC[v]) begin
      base = upd_cnt;
      sel_on; send_word(VEC[v][15:8]); sel_off;
      exp_bank[5*VEC[v][7:5] +: 5] = VEC[v][4:0];
      check(stage == exp_bank, "R6 addressed entry", stage, exp_bank);
      check(upd_cnt == base + 1, "R8 one pulse per word", upd_cnt - base, 1);
    end

    // R3 stray fall before arming rise
    base = upd_cnt;
    @(negedge clk); sclk = 1'b1; wait_n(HALF);
    sel_on; sdata = 1'b1; sclk = 1'b0; wait_n(HALF);
    send_word(8'h2A); sel_off;
    exp_bank[10 +: 5] = 5'h05;
    check(stage == exp_bank, "R3 unarmed fall ignored", stage, exp_bank);
    check(upd_cnt == base + 1, "R3 pulse count", upd_cnt - base, 1);

    // R7 extra bits dropped
    base = upd_cnt;
    sel_on; send_word(8'hE4); send_bit(1); send_bit(1); send_bit(1); sel_off;
    exp_bank[20 +: 5] = 5'h1C;
    check(stage == exp_bank, "R7 extra bits", stage, exp_bank);
    check(upd_cnt == base + 1, "R7 extra pulse", upd_cnt - base, 1);

    // R7 partial word dropped, next word fresh
    base = upd_cnt;
    sel_on; for (int i = 0; i < 5; i++) send_bit(1'b1); sel_off;
    check(stage == exp_bank && upd_cnt == base, "R7 partial word", stage, exp_bank);
    sel_on; send_word(8'h0F); sel_off;
    exp_bank[35 +: 5] = 5'h01;
    check(stage == exp_bank, "R7 fresh word", stage, exp_bank);

    // R2 select high ignores activity
    mode = 1'b0;
    base = upd_cnt;
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    check(stage == exp_bank && upd_cnt == base, "R2 idle select", stage, exp_bank);

    // R4 full chain frame
    base = upd_cnt;
    sel_on; for (int i = 0; i < 40; i++) send_bit(fb[i]); sel_off;
    check(stage == fb, "R4 chain frame", stage, fb);
    check(upd_cnt == base + 40, "R8 pulse per bit", upd_cnt - base, 40);
    check(sdout == fb[0], "R5 sdout head", sdout, fb[0]);

    // R5 daisy chain: 80 bits, old frame leaves in order
    base = upd_cnt; errs = 0;
    sel_on;
    for (int i = 0; i < 40; i++) send_bit(fb[i]);
    for (int i = 0; i < 40; i++) begin
      if (sdout !== fb[i]) errs++;
      send_bit(fa[i]);
    end
    sel_off;
    check(errs == 0, "R5 shifted-out bits", errs, 0);
    check(stage == fa, "R5 chain holds last frame", stage, fa);
    check(upd_cnt == base + 80, "R8 80 pulses", upd_cnt - base, 80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule